// File: doc/BRIEF.md
# Quadrature and Pulse Direction Decoder

This block turns the two raw pulse lines of a rotary encoder or linear scale into single-cycle count strobes for a separate up/down counter. Both lines are brought into the system clock domain through a synchronizer. Each new synchronized sample is then compared with the one before it. The result is either an "up" strobe, a "down" strobe, or nothing.

Two input formats are supported. In phase-shifted mode the lines carry an A/B quadrature pair, and edges are evaluated at one, two or four times the line rate. In pulse mode one line carries up pulses and the other carries down pulses. An invert input swaps the counting sense. Input patterns that no legal signal can produce set a sticky fault flag, and that flag can raise an interrupt. These patterns are both phases changing in one sample, or up and down pulses rising together. The synchronized line levels are always visible on a monitor output, so lines that are not used for counting can serve as general-purpose inputs.

In phase-shifted mode the lines must change at less than a quarter of the clock rate. In pulse mode they must change at less than half of the clock rate.

Top module: `qdec_top`

## Requirements
- R1: After a synchronous reset, `cnt_up`, `cnt_dn`, `err_flag`, `irq` and `mon_lvl` are all 0.
- R2: `mon_lvl` carries the synchronized levels, with bit 0 = line A and bit 1 = line B. A level change that is set up before clock edge k shows up after edge k+1 and not earlier.
- R3: When `fmt_sel`=0 and `res_sel` is 2 or 3 (4x), every single-phase edge gives exactly one strobe. The strobe lasts one cycle and appears after the third clock edge that follows the input change. Direction: the sequence (A,B) = 00→10→11→01→00 counts up, and the reverse sequence counts down. No strobe is produced while the levels do not change.
- R4: When `res_sel`=0 (1x), only a rising edge of A counts. It counts up when B=0 and down when B=1. All other edges produce no strobe.
- R5: When `res_sel`=1 (2x), both edges of A count. A rising A counts up if B=0, and a falling A counts up if B=1; the other cases count down. Edges of B produce no strobe.
- R6: When `dir_inv`=1, every strobe appears on the opposite output. This applies in both formats.
- R7: When `fmt_sel`=1, a rising edge of A gives one up strobe and a rising edge of B gives one down strobe. Falling edges produce nothing.
- R8: When `fmt_sel`=0, a sample in which A and B both change produces no strobe and sets `err_flag`.
- R9: When `fmt_sel`=1, rising edges on A and B in the same sample cancel each other. No strobe is produced and `err_flag` is set.
- R10: `err_flag` stays set until a cycle with `err_clr`=1, and it reads 0 after that edge. If a new fault arrives in that same cycle, the flag stays set. `irq` is 1 exactly when `err_flag`=1 and `irq_en`=1.
- R11: `cnt_up` and `cnt_dn` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Raw line A (phase A, or up pulses) |
| enc_b | input | 1 | Raw line B (phase B, or down pulses) |
| fmt_sel | input | 1 | 0 = A/B quadrature, 1 = separate up/down pulses |
| res_sel | input | 2 | Edge evaluation: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| dir_inv | input | 1 | Swap the up and down outputs |
| irq_en | input | 1 | Let the fault flag drive `irq` |
| err_clr | input | 1 | Clear the sticky fault flag |
| cnt_up | output | 1 | One-cycle up strobe |
| cnt_dn | output | 1 | One-cycle down strobe |
| err_flag | output | 1 | Sticky fault flag |
| irq | output | 1 | Interrupt request |
| mon_lvl | output | 2 | Synchronized levels, {B, A} |

## Verification
A line change that is driven before clock edge k has the following effects. It appears on `mon_lvl` after edge k+1. It produces its strobe, or sets `err_flag`, after edge k+2. A clear or a change of `irq_en` takes effect after the next edge, or at once in the case of `irq`.

For every drive, the bench queues the expected strobe pair, or an explicit "no strobe", tagged with the cycle number three edges later. A monitor compares that entry at the falling edge of exactly that cycle, and it flags any strobe that arrives when no entry is due. Drives are spaced five cycles apart, which keeps each change inside the legal input rate. Flag and monitor checks are sampled at falling edges that are counted from the drive in the same way.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic [1:0] {
        RES_X1     = 2'd0,
        RES_X2     = 2'd1,
        RES_X4     = 2'd2,
        RES_X4_ALT = 2'd3
    } res_e;

    typedef enum logic {
        FMT_QUAD  = 1'b0,
        FMT_PULSE = 1'b1
    } fmt_e;

    // bit 0 = line A, bit 1 = line B
    typedef struct packed {
        logic b;
        logic a;
    } pair_t;

    localparam int PAIR_W = $bits(pair_t);

    typedef struct packed {
        pair_t now;
        pair_t was;
    } edge_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic fault;
    } step_t;

    localparam step_t STEP_IDLE = '0;

    function automatic logic rose(input logic now_v, input logic was_v);
        return now_v & ~was_v;
    endfunction

    // Phase-shifted decode. After an A edge, unequal levels mean forward;
    // after a B edge, equal levels mean forward.
    function automatic step_t quad_step(input edge_t e, input res_e res);
        step_t s;
        logic  a_chg;
        logic  b_chg;
        logic  fwd_a;
        logic  fwd_b;
        s     = STEP_IDLE;
        a_chg = e.now.a ^ e.was.a;
        b_chg = e.now.b ^ e.was.b;
        fwd_a = e.now.a ^ e.now.b;
        fwd_b = ~fwd_a;
        if (a_chg && b_chg) begin
            s.fault = 1'b1;
        end else if (a_chg) begin
            if (res != RES_X1 || e.now.a) begin
                s.up = fwd_a;
                s.dn = ~fwd_a;
            end
        end else if (b_chg) begin
            if (res == RES_X4 || res == RES_X4_ALT) begin
                s.up = fwd_b;
                s.dn = ~fwd_b;
            end
        end
        return s;
    endfunction

    // Separate pulse lines: rising A = up, rising B = down, both = clash.
    function automatic step_t pulse_step(input edge_t e);
        step_t s;
        logic  ra;
        logic  rb;
        ra      = rose(e.now.a, e.was.a);
        rb      = rose(e.now.b, e.was.b);
        s.up    = ra & ~rb;
        s.dn    = rb & ~ra;
        s.fault = ra & rb;
        return s;
    endfunction

    function automatic step_t apply_dir(input step_t s, input logic inv);
        step_t r;
        r       = s;
        r.up    = inv ? s.dn : s.up;
        r.dn    = inv ? s.up : s.dn;
        return r;
    endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stg
        logic [WIDTH-1:0] r;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= '0;
                else     r <= g_stg[i-1].r;
            end
        end
    end

    assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/qdec_edge.sv
module qdec_edge
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t lvl,
    output edge_t ev
);

    pair_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign ev.now = lvl;
    assign ev.was = prev_q;

endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  edge_t ev,
    input  fmt_e  fmt,
    input  res_e  res,
    input  logic  inv,
    output logic  up_q,
    output logic  dn_q,
    output logic  fault_evt
);

    step_t raw;
    step_t dirn;

    always_comb begin
        if (fmt == FMT_PULSE) raw = pulse_step(ev);
        else                  raw = quad_step(ev, res);
        dirn = apply_dir(raw, inv);
    end

    assign fault_evt = raw.fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= dirn.up;
            dn_q <= dirn.dn;
        end
    end

endmodule

// File: rtl/qdec_fault.sv
module qdec_fault (
    input  logic clk,
    input  logic rst,
    input  logic fault_evt,
    input  logic clr,
    input  logic irq_en,
    output logic err_q,
    output logic irq
);

    // A fresh fault outranks a clear issued in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= fault_evt | (err_q & ~clr);
    end

    assign irq = err_q & irq_en;

endmodule

// File: rtl/qdec_top.sv
module qdec_top
    import qdec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enc_a,
    input  logic       enc_b,
    input  logic       fmt_sel,
    input  logic [1:0] res_sel,
    input  logic       dir_inv,
    input  logic       irq_en,
    input  logic       err_clr,
    output logic       cnt_up,
    output logic       cnt_dn,
    output logic       err_flag,
    output logic       irq,
    output logic [1:0] mon_lvl
);

    logic [PAIR_W-1:0] raw_bits;
    logic [PAIR_W-1:0] sync_bits;
    pair_t             lvl_now;
    edge_t             ev;
    logic              fault_evt;

    assign raw_bits = {enc_b, enc_a};

    qdec_sync #(.WIDTH(PAIR_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bits),
        .q   (sync_bits)
    );

    assign lvl_now = pair_t'(sync_bits);
    assign mon_lvl = sync_bits;

    qdec_edge u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (lvl_now),
        .ev  (ev)
    );

    qdec_step u_step (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .fmt       (fmt_e'(fmt_sel)),
        .res       (res_e'(res_sel)),
        .inv       (dir_inv),
        .up_q      (cnt_up),
        .dn_q      (cnt_dn),
        .fault_evt (fault_evt)
    );

    qdec_fault u_fault (
        .clk       (clk),
        .rst       (rst),
        .fault_evt (fault_evt),
        .clr       (err_clr),
        .irq_en    (irq_en),
        .err_q     (err_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/qdec_chk.sv
module qdec_chk (
    input logic       clk,
    input logic       rst,
    input logic       enc_a,
    input logic       enc_b,
    input logic       fmt_sel,
    input logic       irq_en,
    input logic       err_clr,
    input logic       cnt_up,
    input logic       cnt_dn,
    input logic       err_flag,
    input logic       irq,
    input logic [1:0] mon_lvl,
    input logic [1:0] lvl_now,
    input logic [1:0] lvl_was,
    input logic       fault_evt
);

    // Cycles since reset, saturating; guards the two-deep look-back.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R2: monitor shows inputs two edges late (two-stage synchronizer)
    p_mon_delay_r2: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (mon_lvl == $past({enc_b, enc_a}, 2)));

    // R3: unchanged levels give no strobe
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (lvl_now == lvl_was) |=> (!cnt_up && !cnt_dn));

    // R8: double phase change is a fault without strobe
    p_double_change_r8: assert property (@(posedge clk) disable iff (rst)
        (!fmt_sel && (lvl_now[0] != lvl_was[0]) && (lvl_now[1] != lvl_was[1]))
        |=> (err_flag && !cnt_up && !cnt_dn));

    // R9: simultaneous up/down rises cancel and fault
    p_pulse_clash_r9: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel && lvl_now[0] && !lvl_was[0] && lvl_now[1] && !lvl_was[1])
        |=> (err_flag && !cnt_up && !cnt_dn));

    // R10: sticky until cleared
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !err_clr) |=> err_flag);

    // R10: clear without a fresh fault empties the flag
    p_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !fault_evt) |=> !err_flag);

    // R10: a newly set flag with interrupts enabled requests one
    p_irq_raise_r10: assert property (@(posedge clk) disable iff (rst)
        ($rose(err_flag) && irq_en) |-> irq);

    // R11: never both strobes
    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        !(cnt_up && cnt_dn));

endmodule

bind qdec_top qdec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enc_a     (enc_a),
    .enc_b     (enc_b),
    .fmt_sel   (fmt_sel),
    .irq_en    (irq_en),
    .err_clr   (err_clr),
    .cnt_up    (cnt_up),
    .cnt_dn    (cnt_dn),
    .err_flag  (err_flag),
    .irq       (irq),
    .mon_lvl   (mon_lvl),
    .lvl_now   (sync_bits),
    .lvl_was   (ev.was),
    .fault_evt (fault_evt)
);

// File: tb/tb_qdec_top.sv
module tb_qdec_top;

    logic       clk;
    logic       rst;
    logic       enc_a;
    logic       enc_b;
    logic       fmt_sel;
    logic [1:0] res_sel;
    logic       dir_inv;
    logic       irq_en;
    logic       err_clr;
    logic       cnt_up;
    logic       cnt_dn;
    logic       err_flag;
    logic       irq;
    logic [1:0] mon_lvl;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;
    bit both_seen = 0;

    int       q_due[$];
    bit [1:0] q_exp[$];
    string    q_req[$];

    qdec_top dut (
        .clk      (clk),
        .rst      (rst),
        .enc_a    (enc_a),
        .enc_b    (enc_b),
        .fmt_sel  (fmt_sel),
        .res_sel  (res_sel),
        .dir_inv  (dir_inv),
        .irq_en   (irq_en),
        .err_clr  (err_clr),
        .cnt_up   (cnt_up),
        .cnt_dn   (cnt_dn),
        .err_flag (err_flag),
        .irq      (irq),
        .mon_lvl  (mon_lvl)
    );

    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Position around the quadrature cycle 00,10,11,01 (written as A,B).
    function automatic int qpos(input bit a, input bit b);
        case ({a, b})
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    // Expected {up,dn} for a move from (pa,pb) to (na,nb).
    function automatic bit [1:0] model(input bit pa, input bit pb, input bit na, input bit nb);
        int d;
        bit up;
        bit dn;
        up = 0;
        dn = 0;
        if (fmt_sel == 1'b0) begin
            d = (qpos(na, nb) - qpos(pa, pb) + 4) % 4;
            if (d == 1) up = 1;
            else if (d == 3) dn = 1;
            if (res_sel == 2'd0 && !(na && !pa)) begin up = 0; dn = 0; end
            if (res_sel == 2'd1 && (na == pa))   begin up = 0; dn = 0; end
        end else begin
            up = (na && !pa) && !(nb && !pb);
            dn = (nb && !pb) && !(na && !pa);
        end
        if (dir_inv) return {dn, up};
        return {up, dn};
    endfunction

    // Driver: change the lines at a falling edge and queue the result due three edges later.
    task automatic drive(input bit a, input bit b, input string req);
        bit [1:0] e;
        e = model(enc_a, enc_b, a, b);
        enc_a = a;
        enc_b = b;
        q_due.push_back(cyc + 3);
        q_exp.push_back(e);
        q_req.push_back(req);
    endtask

    task automatic step(input bit a, input bit b, input string req);
        @(negedge clk);
        drive(a, b, req);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compare strobes against the queued expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (cnt_up && cnt_dn) both_seen = 1;
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                check(q_req[0], int'({cnt_up, cnt_dn}), int'(q_exp[0]));
                void'(q_due.pop_front());
                void'(q_exp.pop_front());
                void'(q_req.pop_front());
            end else if (cnt_up || cnt_dn) begin
                check("R3 unexpected strobe", int'({cnt_up, cnt_dn}), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enc_a = 0; enc_b = 0; fmt_sel = 0; res_sel = 2'd2;
        dir_inv = 0; irq_en = 0; err_clr = 0;
        repeat (3) @(negedge clk);
        check("R1 cnt_up", cnt_up, 0);
        check("R1 cnt_dn", cnt_dn, 0);
        check("R1 err_flag", err_flag, 0);
        check("R1 irq", irq, 0);
        check("R1 mon_lvl", mon_lvl, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2 monitor timing, together with the first 4x step (R3)
        @(negedge clk);
        drive(1, 0, "R3 4x up A rise");
        @(negedge clk);
        check("R2 mon before", mon_lvl, 0);
        @(negedge clk);
        check("R2 mon after", mon_lvl, 1);
        repeat (2) @(negedge clk);

        step(1, 1, "R3 4x up B rise");
        step(0, 1, "R3 4x up A fall");
        step(0, 0, "R3 4x up B fall");
        step(0, 1, "R3 4x down B rise");
        step(1, 1, "R3 4x down A rise");
        step(1, 0, "R3 4x down B fall");
        step(0, 0, "R3 4x down A fall");

        res_sel = 2'd1;
        step(1, 0, "R5 2x A rise");
        step(1, 1, "R5 2x B edge ignored");
        step(0, 1, "R5 2x A fall");
        step(0, 0, "R5 2x B edge ignored");

        res_sel = 2'd0;
        step(1, 0, "R4 1x A rise B=0");
        step(1, 1, "R4 1x B ignored");
        step(0, 1, "R4 1x A fall ignored");
        step(1, 1, "R4 1x A rise B=1");
        step(0, 1, "R4 1x A fall ignored");
        step(0, 0, "R4 1x B ignored");

        res_sel = 2'd3;
        step(1, 0, "R3 code 3 acts as 4x");
        step(0, 0, "R3 code 3 acts as 4x back");

        res_sel = 2'd2;
        dir_inv = 1;
        step(1, 0, "R6 inverted 4x");
        step(1, 1, "R6 inverted 4x");
        dir_inv = 0;

        step(0, 0, "R8 double change no strobe");
        check("R8 err set", err_flag, 1);
        check("R10 irq masked", irq, 0);
        repeat (3) @(negedge clk);
        check("R10 err sticky", err_flag, 1);
        irq_en = 1;
        #1;
        check("R10 irq enabled", irq, 1);
        @(negedge clk);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        check("R10 err cleared", err_flag, 0);
        check("R10 irq dropped", irq, 0);

        fmt_sel = 1;
        step(1, 0, "R7 up pulse");
        step(0, 0, "R7 falling ignored");
        step(0, 1, "R7 down pulse");
        step(0, 0, "R7 falling ignored");
        dir_inv = 1;
        step(1, 0, "R6 inverted pulse");
        step(0, 0, "R6 inverted falling");
        dir_inv = 0;
        step(1, 1, "R9 clash cancels");
        check("R9 err set", err_flag, 1);
        check("R10 irq on clash", irq, 1);
        check("R11 never both strobes", both_seen, 0);
        check("R3 queue drained", q_due.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule